// File: doc/BRIEF.md
# Packed 16-bit Lane Shift Unit

This execution unit shifts every 16-bit lane of a source word by the same amount and returns the packed result one clock later. The lanes are independent. The amount comes from either a second source operand or a 4-bit field inside the instruction word. The supported operations are:

- logical shift left;
- logical shift right and arithmetic shift right, each with an optional round-half-up variant;
- saturating shift left;
- a direction-selecting shift that takes a signed 5-bit amount, in plain and rounding versions.

The unit decodes the instruction word itself. For a word it does not recognise, it pulses an illegal-instruction strobe instead of producing a result. Any saturating lane sets a sticky flag. The flag stays set until the surrounding logic clears it.

The unit sits between register read and write-back. Each cycle the caller presents `instr`, `src_a`, `src_b` and `in_valid`. One cycle later `out_valid` or `illegal` pulses. `result` holds its value until the next legal operation.

Top module: `pshift16_unit`

## Requirements
- R1: A word is legal only when bits 6:0 are 1111111 and bits 14:12 are 000. The operation comes from bits 31:25, as follows:
  - 0101000: arithmetic right shift
  - 0110000: rounding arithmetic right shift
  - 0101001: logical right shift
  - 0110001: rounding logical right shift
  - 0101010: left shift
  - 0110010: saturating left shift
  - 0101011: signed-amount shift
  - 0110011: rounding signed-amount shift
- R2: In the immediate forms, the amount is instruction bits 23:20 and bit 24 selects the variant:
  - 0111000: arithmetic right shift; bit 24 = 1 adds rounding.
  - 0111001: logical right shift; bit 24 = 1 adds rounding.
  - 0111010: left shift; bit 24 = 1 makes it saturating.
- R3: XLEN/16 lanes are packed with lane 0 in bits 15:0. Outside the signed-amount forms, only `src_b[3:0]` forms the amount, and every lane uses that same amount.
- R4: A plain left shift drops the bits shifted out of the lane. A logical right shift fills with zeros. An arithmetic right shift fills with copies of bit 15.
- R5: Each rounding right shift adds the last bit shifted out to the truncated lane. An amount of 0 returns the lane unchanged.
- R6: A saturating left shift of a lane saturates when the amount exceeds the lane's count of redundant sign bits. A saturated lane becomes 0x8000 if its input was negative and 0x7FFF otherwise. A lane that does not saturate gets the plain left-shifted value.
- R7: A signed-amount shift reads `src_b[4:0]` as a two's-complement number. A value of 0 or more performs the saturating left shift of R6. A negative value performs an arithmetic right shift by its magnitude, and a magnitude of 16 is clamped to 15.
- R8: A rounding signed-amount shift with a negative amount uses the rounding arithmetic right shift of R5, with the same clamp. A non-negative amount behaves as in R7.
- R9: `sat_flag` rises at the edge that registers a legal operation in which any lane saturated. It then stays set.
- R10: `sat_clr` clears `sat_flag` at the next edge. The clear wins over a saturation in the same cycle.
- R11: An unrecognised word with `in_valid` pulses `illegal` one cycle later, without `out_valid`. It leaves `result` and `sat_flag` unchanged.
- R12: After reset, `out_valid`, `illegal`, `result` and `sat_flag` are all 0. `out_valid` follows a legal `in_valid` by exactly one cycle, and `result` changes only with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | XLEN | Packed lanes to be shifted |
| src_b | input | XLEN | Amount source for the register forms |
| sat_clr | input | 1 | Clear the sticky saturation flag |
| out_valid | output | 1 | Result registered for a legal operation |
| illegal | output | 1 | Unrecognised instruction word was presented |
| result | output | XLEN | Packed shifted lanes |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Two cases are hard to reach from the ports. The first is a clear that arrives in the same cycle as an operation that saturates. The second is a signed amount of exactly -16, which exercises the clamp to 15. Directed stimulus issues a saturating shift together with `sat_clr`, then issues a signed-amount shift with `src_b[4:0]` = 10000 on both a positive and a negative lane. A long random run then mixes every legal encoding with junk encodings, idle cycles and random clears. A behavioural reference model predicts every output on every clock.

// File: rtl/pshift16_pkg.sv
package pshift16_pkg;

    localparam logic [6:0] OPC_PSHIFT = 7'b1111111;
    localparam logic [2:0] F3_PSHIFT  = 3'b000;

    localparam logic [6:0] F7_SRA     = 7'b0101000;
    localparam logic [6:0] F7_SRA_RND = 7'b0110000;
    localparam logic [6:0] F7_SRL     = 7'b0101001;
    localparam logic [6:0] F7_SRL_RND = 7'b0110001;
    localparam logic [6:0] F7_SLL     = 7'b0101010;
    localparam logic [6:0] F7_SLL_SAT = 7'b0110010;
    localparam logic [6:0] F7_SGN     = 7'b0101011;
    localparam logic [6:0] F7_SGN_RND = 7'b0110011;
    localparam logic [6:0] F7_I_SRA   = 7'b0111000;
    localparam logic [6:0] F7_I_SRL   = 7'b0111001;
    localparam logic [6:0] F7_I_SLL   = 7'b0111010;

    localparam int LANE_W = 16;
    localparam int AMT_W  = 4;

    typedef enum logic [2:0] {
        KIND_SRA,
        KIND_SRL,
        KIND_SLL,
        KIND_SLL_SAT,
        KIND_SIGNED
    } kind_e;

    typedef struct packed {
        logic             legal;
        kind_e            kind;
        logic             rnd;
        logic             imm_form;
        logic [AMT_W-1:0] imm_amt;
    } dec_t;

    typedef enum logic [1:0] {
        MODE_SHL,
        MODE_SHL_SAT,
        MODE_SHR_LOG,
        MODE_SHR_ARI
    } mode_e;

    typedef struct packed {
        mode_e            mode;
        logic             rnd;
        logic [AMT_W-1:0] amt;
    } lane_ctl_t;

    // Magnitude of a negative 5-bit amount; a magnitude of 16 becomes 15.
    function automatic logic [AMT_W-1:0] neg_mag_clamp(input logic [AMT_W:0] s);
        logic [AMT_W:0] m;
        m = ~s + 1'b1;
        return m[AMT_W] ? {AMT_W{1'b1}} : m[AMT_W-1:0];
    endfunction

endpackage

// File: rtl/pshift16_decode.sv
module pshift16_decode
    import pshift16_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic [6:0] f7;
    logic       base_ok;
    logic [5:0] unused_fields;

    assign f7            = instr[31:25];
    assign base_ok       = (instr[6:0] == OPC_PSHIFT) && (instr[14:12] == F3_PSHIFT);
    assign unused_fields = {instr[19:15] == 5'd0, instr[11:7] == 5'd0};

    always_comb begin
        dec          = '0;
        dec.kind     = KIND_SRA;
        dec.imm_amt  = instr[23:20];
        dec.legal    = base_ok;
        unique case (f7)
            F7_SRA:     dec.kind = KIND_SRA;
            F7_SRA_RND: begin dec.kind = KIND_SRA;     dec.rnd = 1'b1; end
            F7_SRL:     dec.kind = KIND_SRL;
            F7_SRL_RND: begin dec.kind = KIND_SRL;     dec.rnd = 1'b1; end
            F7_SLL:     dec.kind = KIND_SLL;
            F7_SLL_SAT: dec.kind = KIND_SLL_SAT;
            F7_SGN:     dec.kind = KIND_SIGNED;
            F7_SGN_RND: begin dec.kind = KIND_SIGNED;  dec.rnd = 1'b1; end
            F7_I_SRA: begin
                dec.kind     = KIND_SRA;
                dec.rnd      = instr[24];
                dec.imm_form = 1'b1;
            end
            F7_I_SRL: begin
                dec.kind     = KIND_SRL;
                dec.rnd      = instr[24];
                dec.imm_form = 1'b1;
            end
            F7_I_SLL: begin
                dec.kind     = instr[24] ? KIND_SLL_SAT : KIND_SLL;
                dec.imm_form = 1'b1;
            end
            default:    dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/pshift16_amt.sv
module pshift16_amt
    import pshift16_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  dec_t            dec,
    input  logic [XLEN-1:0] src_b,
    output lane_ctl_t       ctl
);
    logic [AMT_W:0]       sgn_amt;
    logic [XLEN-AMT_W-2:0] unused_hi;

    assign sgn_amt   = src_b[AMT_W:0];
    assign unused_hi = src_b[XLEN-1:AMT_W+1];

    always_comb begin
        ctl.rnd  = dec.rnd;
        ctl.amt  = dec.imm_form ? dec.imm_amt : src_b[AMT_W-1:0];
        ctl.mode = MODE_SHR_ARI;
        unique case (dec.kind)
            KIND_SRA:     ctl.mode = MODE_SHR_ARI;
            KIND_SRL:     ctl.mode = MODE_SHR_LOG;
            KIND_SLL:     ctl.mode = MODE_SHL;
            KIND_SLL_SAT: ctl.mode = MODE_SHL_SAT;
            KIND_SIGNED: begin
                if (sgn_amt[AMT_W]) begin
                    ctl.mode = MODE_SHR_ARI;
                    ctl.amt  = neg_mag_clamp(sgn_amt);
                end else begin
                    ctl.mode = MODE_SHL_SAT;
                    ctl.amt  = sgn_amt[AMT_W-1:0];
                end
            end
            default:      ctl.mode = MODE_SHR_ARI;
        endcase
    end
endmodule

// File: rtl/pshift16_lane.sv
module pshift16_lane
    import pshift16_pkg::*;
(
    input  lane_ctl_t         ctl,
    input  logic [LANE_W-1:0] a,
    output logic [LANE_W-1:0] y,
    output logic              sat
);
    logic [2*LANE_W-1:0]     wide;
    logic                    fits;
    logic [LANE_W:0]         src;
    logic signed [LANE_W:0]  trunc;
    logic                    rbit;
    logic [LANE_W-1:0]       right;
    logic                    unused_top;

    always_comb begin
        wide  = {{LANE_W{a[LANE_W-1]}}, a} << ctl.amt;
        fits  = (wide[2*LANE_W-1:LANE_W-1] == '0) || (wide[2*LANE_W-1:LANE_W-1] == '1);
        src   = (ctl.mode == MODE_SHR_ARI) ? {a[LANE_W-1], a} : {1'b0, a};
        trunc = $signed(src) >>> ctl.amt;
        rbit  = (ctl.rnd && (ctl.amt != '0)) ? src[ctl.amt - 4'd1] : 1'b0;
        right = trunc[LANE_W-1:0] + {{(LANE_W-1){1'b0}}, rbit};
    end

    assign unused_top = trunc[LANE_W];

    always_comb begin
        sat = 1'b0;
        unique case (ctl.mode)
            MODE_SHL:     y = wide[LANE_W-1:0];
            MODE_SHL_SAT: begin
                if (!fits) begin
                    sat = 1'b1;
                    y   = a[LANE_W-1] ? 16'h8000 : 16'h7FFF;
                end else begin
                    y   = wide[LANE_W-1:0];
                end
            end
            default:      y = right;
        endcase
    end
endmodule

// File: rtl/pshift16_unit.sv
module pshift16_unit
    import pshift16_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic            sat_clr,
    output logic            out_valid,
    output logic            illegal,
    output logic [XLEN-1:0] result,
    output logic            sat_flag
);
    localparam int LANES = XLEN / LANE_W;

    dec_t              dec;
    lane_ctl_t         ctl;
    logic [XLEN-1:0]   lane_y;
    logic [LANES-1:0]  lane_sat;
    logic              any_sat;
    logic              take;

    pshift16_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    pshift16_amt #(.XLEN(XLEN)) u_amt (
        .dec   (dec),
        .src_b (src_b),
        .ctl   (ctl)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pshift16_lane u_lane (
            .ctl (ctl),
            .a   (src_a[g*LANE_W +: LANE_W]),
            .y   (lane_y[g*LANE_W +: LANE_W]),
            .sat (lane_sat[g])
        );
    end

    assign any_sat = |lane_sat;
    assign take    = in_valid && dec.legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            illegal   <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= take;
            illegal   <= in_valid && !dec.legal;
            if (take) begin
                result <= lane_y;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sat_flag <= 1'b0;
        end else if (sat_clr) begin
            sat_flag <= 1'b0;
        end else if (take && any_sat) begin
            sat_flag <= 1'b1;
        end
    end
endmodule

module pshift16_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            sat_clr,
    input logic            out_valid,
    input logic            illegal,
    input logic [XLEN-1:0] result,
    input logic            sat_flag
);
    a_r12_one_strobe: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid ^ illegal));
    a_r12_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !illegal));
    a_r12_result_holds: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(result));
    a_r11_illegal_keeps_result: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $stable(result));
    a_r11_illegal_keeps_flag: assert property (@(posedge clk) disable iff (rst)
        (illegal && !$past(sat_clr)) |-> $stable(sat_flag));
    a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
        sat_clr |=> !sat_flag);
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !sat_clr) |=> sat_flag);
    a_r9_rise_with_result: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_flag) |-> out_valid);
endmodule

bind pshift16_unit pshift16_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .sat_clr   (sat_clr),
    .out_valid (out_valid),
    .illegal   (illegal),
    .result    (result),
    .sat_flag  (sat_flag)
);

// File: tb/pshift16_unit_tb.sv
`timescale 1ns/1ps
module pshift16_unit_tb;
    localparam int XLEN = 64;
    localparam int LANES = XLEN / 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [31:0]     instr = '0;
    logic [XLEN-1:0] src_a = '0;
    logic [XLEN-1:0] src_b = '0;
    logic            sat_clr = 1'b0;
    logic            out_valid;
    logic            illegal;
    logic [XLEN-1:0] result;
    logic            sat_flag;

    always #4 clk = ~clk;

    pshift16_unit #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .sat_clr(sat_clr),
        .out_valid(out_valid), .illegal(illegal), .result(result), .sat_flag(sat_flag)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit checking = 0;
    bit done = 0;

    // reference model state
    logic [XLEN-1:0] m_rd = '0;
    bit    m_ov = 0, m_ill = 0, m_sat = 0;
    string m_tag = "R12";
    string m_ftag = "R9";

    function automatic int ref_lane(int kind, bit rnd, int a, int sh, output bit sat);
        int sa;
        int r;
        longint p;
        sa = (a >= 32768) ? a - 65536 : a;
        sat = 0;
        r = 0;
        case (kind)
            0: begin
                r = sa >>> sh;
                if (rnd && sh > 0) r = r + ((sa >>> (sh - 1)) & 1);
            end
            1: begin
                r = a >> sh;
                if (rnd && sh > 0) r = r + ((a >> (sh - 1)) & 1);
            end
            2: r = a << sh;
            default: begin
                p = longint'(sa) * (longint'(1) << sh);
                if (p > 32767) begin sat = 1; r = 32767; end
                else if (p < -32768) begin sat = 1; r = 32768; end
                else r = int'(p);
            end
        endcase
        return r & 65535;
    endfunction

    // kinds: 0 arith right, 1 logical right, 2 left, 3 saturating left, 4 signed amount
    function automatic logic [XLEN-1:0] ref_word(logic [31:0] ins, logic [XLEN-1:0] a,
            logic [XLEN-1:0] b, output bit legal, output bit sat_any, output string tag);
        logic [6:0] f7;
        int kind;
        bit rnd, imm;
        int sh, s5, m, k2, lv;
        bit ls;
        logic [XLEN-1:0] w;
        f7 = ins[31:25];
        legal = (ins[6:0] == 7'b1111111) && (ins[14:12] == 3'b000);
        rnd = 0; imm = 0; kind = 0; tag = "R4";
        case (f7)
            7'b0101000: kind = 0;
            7'b0110000: begin kind = 0; rnd = 1; end
            7'b0101001: kind = 1;
            7'b0110001: begin kind = 1; rnd = 1; end
            7'b0101010: kind = 2;
            7'b0110010: kind = 3;
            7'b0101011: kind = 4;
            7'b0110011: begin kind = 4; rnd = 1; end
            7'b0111000: begin kind = 0; rnd = ins[24]; imm = 1; end
            7'b0111001: begin kind = 1; rnd = ins[24]; imm = 1; end
            7'b0111010: begin kind = ins[24] ? 3 : 2; imm = 1; end
            default: legal = 0;
        endcase
        if (kind == 3) tag = "R6";
        else if (kind == 4) tag = rnd ? "R8" : "R7";
        else if (rnd) tag = "R5";
        tag = {tag, imm ? " R2" : " R1", " R3"};
        sh = imm ? int'(ins[23:20]) : int'(b[3:0]);
        s5 = int'(b[4:0]);
        sat_any = 0;
        w = '0;
        for (int i = 0; i < LANES; i++) begin
            lv = int'((a >> (16 * i)) & 64'hFFFF);
            if (kind == 4) begin
                if (s5 < 16) k2 = ref_lane(3, 0, lv, s5, ls);
                else begin
                    m = 32 - s5;
                    if (m == 16) m = 15;
                    k2 = ref_lane(0, rnd, lv, m, ls);
                end
            end else begin
                k2 = ref_lane(kind, rnd, lv, sh, ls);
            end
            if (ls) sat_any = 1;
            w[16*i +: 16] = k2[15:0];
        end
        return w;
    endfunction

    always @(posedge clk) begin
        logic [XLEN-1:0] r;
        bit lg, sa, ns;
        string tg;
        if (rst) begin
            m_ov = 0; m_ill = 0; m_rd = '0; m_sat = 0; m_tag = "R12"; m_ftag = "R12";
        end else begin
            ns = m_sat;
            m_ov = 0; m_ill = 0;
            m_ftag = "R9";
            if (in_valid) begin
                r = ref_word(instr, src_a, src_b, lg, sa, tg);
                if (lg) begin
                    m_ov = 1; m_rd = r; m_tag = tg;
                    if (sa) ns = 1;
                end else begin
                    m_ill = 1; m_tag = "R11"; m_ftag = "R11";
                end
            end
            if (sat_clr) begin ns = 0; m_ftag = "R10"; end
            m_sat = ns;
        end
    end

    task automatic chk(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (checking && !done) begin
            chk(m_ill ? "R11" : "R12", "out_valid", XLEN'(out_valid), XLEN'(m_ov));
            chk(m_ill ? "R11" : "R12", "illegal", XLEN'(illegal), XLEN'(m_ill));
            chk(m_tag, "result", result, m_rd);
            chk(m_ftag, "sat_flag", XLEN'(sat_flag), XLEN'(m_sat));
        end
    end

    function automatic logic [31:0] mkr(logic [6:0] f7);
        return {f7, 5'd5, 5'd6, 3'b000, 5'd7, 7'b1111111};
    endfunction

    function automatic logic [31:0] mki(logic [6:0] f7, logic b24, logic [3:0] amt);
        return {f7, b24, amt, 5'd6, 3'b000, 5'd7, 7'b1111111};
    endfunction

    task automatic issue(logic [31:0] ins, logic [XLEN-1:0] a, logic [XLEN-1:0] b, logic clr);
        @(negedge clk);
        in_valid = 1; instr = ins; src_a = a; src_b = b; sat_clr = clr;
    endtask

    task automatic idle(logic clr);
        @(negedge clk);
        in_valid = 0; sat_clr = clr;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL R12 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [6:0] f7s [11];
        f7s = '{7'b0101000, 7'b0110000, 7'b0101001, 7'b0110001, 7'b0101010, 7'b0110010,
                7'b0101011, 7'b0110011, 7'b0111000, 7'b0111001, 7'b0111010};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        checking = 1;                                   // R12 reset state checked here
        idle(0);
        // R4 R3: left shift by 4, high bits of src_b ignored
        issue(mkr(7'b0101010), 64'h8001_1234_00FF_F00F, 64'hFFFF_FFF4, 0);
        // R4: logical and arithmetic right
        issue(mkr(7'b0101001), 64'h8000_FFFF_1234_0001, 64'h3, 0);
        issue(mkr(7'b0101000), 64'h8000_FFFF_7FFF_0001, 64'h23, 0);
        // R5: rounding, zero amount passes through
        issue(mkr(7'b0110000), 64'h8001_7FFF_0003_FFFF, 64'h0, 0);
        issue(mkr(7'b0110000), 64'h8001_7FFF_0003_FFFF, 64'h1, 0);
        issue(mkr(7'b0110001), 64'hFFFF_8000_0005_0006, 64'h2, 0);
        // R2: immediate forms
        issue(mki(7'b0111000, 1, 4'd3), 64'hF00C_0004_7FFF_8000, 64'h0, 0);
        issue(mki(7'b0111001, 0, 4'd15), 64'hF00C_0004_7FFF_8000, 64'h0, 0);
        issue(mki(7'b0111010, 0, 4'd1), 64'h4000_C000_1111_8000, 64'h0, 0);
        // R6: saturation both signs, flag set (R9)
        issue(mki(7'b0111010, 1, 4'd1), 64'h4000_BFFF_3FFF_C000, 64'h0, 0);
        idle(0);
        idle(0);
        // R10: clear together with a saturating op
        issue(mkr(7'b0110010), 64'h7000_7000_7000_7000, 64'h4, 1);
        issue(mkr(7'b0110010), 64'h0001_FFFF_0001_FFFF, 64'h4, 0);
        // R7 R8: signed amount incl. -16 clamp
        issue(mkr(7'b0101011), 64'h8000_7FFF_8001_4000, 64'h10, 1);
        issue(mkr(7'b0110011), 64'h8000_7FFF_8001_4000, 64'h10, 0);
        issue(mkr(7'b0110011), 64'h8003_0007_FFFD_0005, 64'h1F, 0);
        issue(mkr(7'b0101011), 64'h0100_FF00_0001_FFFF, 64'h0F, 0);
        // R11: illegal words
        issue(mkr(7'b0111011), 64'h1234, 64'h1, 0);
        issue(mkr(7'b0101000) ^ 32'h0000_1000, 64'h1234, 64'h1, 0);
        issue(mkr(7'b0101010) ^ 32'h0000_0001, 64'h1234, 64'h1, 1);
        idle(0);
        // random mix
        for (int it = 0; it < 600; it++) begin
            int sel;
            logic [31:0] ins;
            sel = int'($urandom_range(0, 13));
            if (sel < 11) begin
                if (f7s[sel][6:2] == 5'b01110) ins = mki(f7s[sel], 1'($urandom), 4'($urandom));
                else ins = mkr(f7s[sel]);
            end else if (sel == 11) ins = mkr(7'($urandom)) ^ 32'h0000_0040;
            else ins = $urandom;
            if ($urandom_range(0, 7) == 0) idle(($urandom_range(0, 5) == 0));
            else issue(ins, {$urandom, $urandom}, {$urandom, $urandom}, ($urandom_range(0, 9) == 0));
        end
        idle(0);
        idle(0);
        done = 1;
        summary();
        $finish;
    end
endmodule